// File: doc/BRIEF.md
# Base-and-Bounds Address Relocation Unit

This block sits between a processor core and memory. It relocates and protects every memory reference. Each user-mode reference carries a program address that begins at zero. The unit forms the physical address by adding a base register to it. In parallel, it compares the untranslated program address against a bounds register. An address at or beyond the bound is turned away with a protection fault, and no valid memory access leaves the unit. Kernel-mode references skip both the add and the check, and their address passes through unchanged.

Only a kernel-mode write on the configuration port can load the base and bounds registers. A user-mode write is dropped and raises a privilege fault. To relocate a program, the kernel stops it, loads new values and restarts it. The result of each reference is registered, giving one cycle of latency.

Top module: `reloc_unit`

## Requirements
- R1: Reset clears base and bounds to zero and drives rsp_valid, rsp_prot_fault and cfg_priv_fault low. Until the kernel loads a nonzero bound, every user-mode request faults.
- R2: A user-mode request at cycle N with req_addr below bounds gives rsp_valid=1 and rsp_addr = (req_addr + base) mod 2^ADDR_W in cycle N+1.
- R3: A user-mode request with req_addr at or above bounds gives rsp_prot_fault=1, rsp_valid=0 and rsp_addr=0 one cycle later. rsp_valid and rsp_prot_fault are never high together.
- R4: The bounds check uses the untranslated program address. The address bounds-1 is accepted and the address bounds is rejected, whatever the base.
- R5: A kernel-mode request (req_kernel=1) gives rsp_valid=1 and rsp_addr = req_addr one cycle later and never faults.
- R6: A kernel-mode write (cfg_we=1, cfg_kernel=1) loads cfg_wdata into base when cfg_sel=0 and into bounds when cfg_sel=1. Requests from the next cycle onward use the new value. A request in the same cycle as the write uses the old value.
- R7: A user-mode write (cfg_we=1, cfg_kernel=0) leaves base and bounds unchanged and pulses cfg_priv_fault high for one cycle, in the cycle after the write.
- R8: A cycle with req_valid=0 gives rsp_valid=0 and rsp_prot_fault=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Memory reference present this cycle |
| req_kernel | input | 1 | Reference issued in kernel mode |
| req_addr | input | ADDR_W | Program (virtual) address |
| cfg_we | input | 1 | Register write strobe |
| cfg_kernel | input | 1 | Write issued in kernel mode |
| cfg_sel | input | 1 | 0 selects base, 1 selects bounds |
| cfg_wdata | input | ADDR_W | Value to load |
| rsp_valid | output | 1 | Physical access issued |
| rsp_addr | output | ADDR_W | Physical address |
| rsp_prot_fault | output | 1 | User reference outside its bound |
| cfg_priv_fault | output | 1 | User-mode register write refused |

## Verification
The bench probes the bound edge, at bounds-1 and at bounds. A design that compared the translated address, or used the wrong inequality, fails there. A base near the top of the address space checks that the sum wraps and is not saturated or faulted. A register write issued in the same cycle as a request checks the old-value rule, which a design that forwards the write data would break. The bench also tries a user-mode write. A design that ignored the mode bit would move the relocation, and the next translation would show it. Kernel requests far past the bound confirm that the check is truly bypassed.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  parameter int unsigned ADDR_W = 32;

  typedef enum logic {
    SEL_BASE   = 1'b0,
    SEL_BOUNDS = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
  parameter int unsigned AW = reloc_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_kernel,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] bounds_o,
  output logic          priv_fault_o
);
  import reloc_pkg::*;

  logic [AW-1:0] base_q, bounds_q;
  logic          priv_q;
  logic          base_en, bounds_en, priv_d;

  always_comb begin
    base_en   = cfg_we && cfg_kernel && (cfg_sel_e'(cfg_sel) == SEL_BASE);
    bounds_en = cfg_we && cfg_kernel && (cfg_sel_e'(cfg_sel) == SEL_BOUNDS);
    priv_d    = cfg_we && !cfg_kernel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      bounds_q <= '0;
      priv_q   <= 1'b0;
    end else begin
      if (base_en)   base_q   <= cfg_wdata;
      if (bounds_en) bounds_q <= cfg_wdata;
      priv_q <= priv_d;
    end
  end

  assign base_o       = base_q;
  assign bounds_o     = bounds_q;
  assign priv_fault_o = priv_q;

  // R7: a user-mode write never alters the registers and is flagged
  assert_user_write_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_kernel) |=> ($stable(base_q) && $stable(bounds_q) && priv_q));

  // R6: a kernel write lands in the selected register
  assert_kernel_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kernel) |=>
      ((cfg_sel_e'($past(cfg_sel)) == SEL_BASE) ? (base_q == $past(cfg_wdata))
                                                : (bounds_q == $past(cfg_wdata))));
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int unsigned AW = reloc_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_kernel,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] bounds_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_fault_o
);
  logic [AW-1:0] sum;
  logic          in_range, pass_d, fault_d;
  logic [AW-1:0] addr_d;
  logic          valid_q, fault_q;
  logic [AW-1:0] addr_q;

  always_comb begin
    sum      = req_addr + base_i;
    in_range = req_addr < bounds_i;
    pass_d   = req_valid && (req_kernel || in_range);
    fault_d  = req_valid && !req_kernel && !in_range;
    if (!pass_d)         addr_d = '0;
    else if (req_kernel) addr_d = req_addr;
    else                 addr_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= pass_d;
      fault_q <= fault_d;
      if (req_valid) addr_q <= addr_d;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_fault_o = fault_q;

  // R3: an access is either issued or faulted, never both
  assert_valid_xor_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && fault_q));

  // R5: kernel references pass through untouched
  assert_kernel_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kernel) |=> (valid_q && !fault_q && addr_q == $past(req_addr)));

  // R8: no request, no response
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!valid_q && !fault_q));

  // R4: user reference above the bound faults
  assert_user_over_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel && req_addr >= bounds_i) |=> (fault_q && addr_q == '0));
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int unsigned ADDR_W = reloc_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kernel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_we,
  input  logic              cfg_kernel,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_prot_fault,
  output logic              cfg_priv_fault
);
  logic [ADDR_W-1:0] base_w, bounds_w;

  reloc_regs #(.AW(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_kernel   (cfg_kernel),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .base_o       (base_w),
    .bounds_o     (bounds_w),
    .priv_fault_o (cfg_priv_fault)
  );

  reloc_xlate #(.AW(ADDR_W)) u_xlate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kernel  (req_kernel),
    .req_addr    (req_addr),
    .base_i      (base_w),
    .bounds_i    (bounds_w),
    .rsp_valid_o (rsp_valid),
    .rsp_addr_o  (rsp_addr),
    .rsp_fault_o (rsp_prot_fault)
  );

  // R1: with a zero bound every user reference faults
  assert_zero_bound_faults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel && bounds_w == '0) |=> rsp_prot_fault);
endmodule

// File: tb/reloc_unit_tb.sv
module reloc_unit_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_kernel;
  logic [AW-1:0] req_addr;
  logic          cfg_we, cfg_kernel, cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          rsp_valid, rsp_prot_fault, cfg_priv_fault;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reloc_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kernel(req_kernel), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_kernel(cfg_kernel), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_prot_fault(rsp_prot_fault), .cfg_priv_fault(cfg_priv_fault)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_kernel = 0; req_addr = '0;
    cfg_we = 0; cfg_kernel = 0; cfg_sel = 0; cfg_wdata = '0;
  endtask

  // Issue one reference; check outputs in the following cycle.
  task automatic ref_check(input string req, input logic kern, input logic [AW-1:0] a,
                           input logic ev, input logic ef, input logic [AW-1:0] ea);
    @(negedge clk);
    req_valid = 1; req_kernel = kern; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, AW'(rsp_valid), AW'(ev));
    check({req, " fault"}, AW'(rsp_prot_fault), AW'(ef));
    check({req, " addr"},  rsp_addr, ea);
  endtask

  task automatic cfg_write(input logic kern, input logic sel, input logic [AW-1:0] d,
                           input logic exp_priv, input string req);
    @(negedge clk);
    cfg_we = 1; cfg_kernel = kern; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    check({req, " priv_fault"}, AW'(cfg_priv_fault), AW'(exp_priv));
    @(negedge clk);
    check({req, " priv_fault pulse ends"}, AW'(cfg_priv_fault), '0);
  endtask

  task automatic test_reset();
    check("R1 rsp_valid at reset", AW'(rsp_valid), '0);
    check("R1 prot_fault at reset", AW'(rsp_prot_fault), '0);
    check("R1 priv_fault at reset", AW'(cfg_priv_fault), '0);
    ref_check("R1 user access after reset", 1'b0, 32'h0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic test_translate();
    cfg_write(1'b1, 1'b0, 32'h0000_1000, 1'b0, "R6 load base");
    cfg_write(1'b1, 1'b1, 32'h0000_0100, 1'b0, "R6 load bounds");
    ref_check("R2 addr 0", 1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_1000);
    ref_check("R2 addr 80", 1'b0, 32'h80, 1'b1, 1'b0, 32'h0000_1080);
    ref_check("R4 bounds-1", 1'b0, 32'hFF, 1'b1, 1'b0, 32'h0000_10FF);
    ref_check("R4 at bounds", 1'b0, 32'h100, 1'b0, 1'b1, 32'h0);
    ref_check("R3 far above", 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic test_kernel();
    ref_check("R5 kernel passthru", 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'hDEAD_BEEF);
    ref_check("R5 kernel past bound", 1'b1, 32'h100, 1'b1, 1'b0, 32'h100);
  endtask

  task automatic test_user_write();
    cfg_write(1'b0, 1'b0, 32'h0005_0000, 1'b1, "R7 user base write");
    cfg_write(1'b0, 1'b1, 32'h0000_0000, 1'b1, "R7 user bounds write");
    ref_check("R7 base unchanged", 1'b0, 32'h10, 1'b1, 1'b0, 32'h0000_1010);
  endtask

  task automatic test_idle();
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    check("R8 idle valid", AW'(rsp_valid), '0);
    check("R8 idle fault", AW'(rsp_prot_fault), '0);
  endtask

  task automatic test_same_cycle();
    @(negedge clk);
    cfg_we = 1; cfg_kernel = 1; cfg_sel = 0; cfg_wdata = 32'h0000_2000;
    req_valid = 1; req_kernel = 0; req_addr = 32'h4;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R6 same-cycle uses old base", rsp_addr, 32'h0000_1004);
    ref_check("R6 next uses new base", 1'b0, 32'h4, 1'b1, 1'b0, 32'h0000_2004);
  endtask

  task automatic test_wrap();
    cfg_write(1'b1, 1'b0, 32'hFFFF_FFF0, 1'b0, "R6 load high base");
    ref_check("R2 wraparound", 1'b0, 32'h20, 1'b1, 1'b0, 32'h0000_0010);
    ref_check("R4 high base bound edge", 1'b0, 32'h100, 1'b0, 1'b1, 32'h0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_translate();
    test_kernel();
    test_user_write();
    test_idle();
    test_same_cycle();
    test_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule